// File: doc/BRIEF.md
# GPIO Pin Bank with Edge Interrupt

A bank of general-purpose I/O pins, one slice per pin, configured through a small register bus. Every pin carries an output latch, a direction bit and an option bit. A pin whose direction bit is set drives its pad from the latch. The option bit then chooses between push-pull and open-drain drive. A pin whose direction bit is clear is an input. Its option bit then arms that pin's external interrupt. One 2-bit sensitivity field, shared by the whole bank, chooses which edges or levels raise requests.

Every pad input passes through a two-flop synchronizer before the edge detector sees it. While a pin's interrupt is disarmed, the detector input is held at logic 1 and does not track the pad. Arming or disarming a pin whose pad is low therefore makes a genuine falling or rising edge at the detector. Software must choose a safe sensitivity before toggling the arm bit: rising-only while arming, falling-only while disarming. Detected events set sticky per-pin pending flags. The interrupt output is a registered OR of those flags.

Top module: `pinbank_edge_irq`

## Requirements
- R1: After reset the latch, direction, option, sensitivity and pending registers read 0, and pad_oe, pad_out and irq are 0.
- R2: A pin with its direction bit at 0 never has pad_oe asserted. In output mode, pad_oe and pad_out follow the configuration one cycle after the register write.
- R3: A read of the latch register (address 0) returns the last value written, whatever the pad levels and the direction.
- R4: In output mode with option bit 1 (push-pull), pad_oe is 1 and pad_out equals the latch bit.
- R5: In output mode with option bit 0 (open-drain), a latch bit of 0 gives pad_oe=1 with pad_out=0, and a latch bit of 1 gives pad_oe=0.
- R6: When the interrupt is disarmed (option 0 in input mode, or any output-mode pin), the detector input is held at 1, so pad activity sets no pending flag.
- R7: Arming an input pin whose pad is low presents a falling edge. The flag sets under sensitivity 10 (falling only), 11 (both edges) or 00 (falling edge and low level), and does not set under 01 (rising only).
- R8: Disarming a pin whose pad is low presents a rising edge. The flag sets under 01 or 11 and does not set under 10.
- R9: A pad transition reaches the detector through two synchronizing flops. With the pin armed, irq rises on the fourth rising clock edge after the pad change and not on the third.
- R10: With sensitivity 00, an armed pin whose pad is held low sets its pending flag again after every clear. Once the pad is high, a clear sticks.
- R11: Pending flags are sticky. Writing 1 to a bit of the pending register (address 4) clears that flag, and writing 0 has no effect. When a clear and a detected event hit the same pin in the same cycle, the flag stays set.
- R12: irq is the OR of all pending flags, registered, so it follows the flags with one cycle of lag.
- R13: Register map: 0 latch, 1 direction, 2 option, 3 sensitivity in bits [1:0], 4 pending, 5 synchronized pad level (read-only). Read data appears with bus_rvalid one cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
Two of the block's functions can land in the same cycle: a write-one-to-clear of a pending flag, and the detection of a new edge on the same pin. The bench first arranges for a flag to be set. It then drives a pad edge and times the clear write so that the bus samples it on exactly the rising clock edge at which the synchronized edge is registered. That is the third rising edge after the pad change. The flag must read back as set afterwards. A separate clear with no edge present must then empty it, which shows that set-over-clear priority, not a failed clear, kept the flag.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LATCH = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_OPT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SENSE = 3'd3;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LEVEL = 3'd5;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge
  import pinbank_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   arm_i,
  input  logic   level_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   pend_o
);
  logic det_w;
  logic prev_q;
  logic pend_q;
  logic rise_w, fall_w, hit_w;

  // Disarmed detector input sits at 1 instead of tracking the pad.
  assign det_w  = arm_i ? level_i : 1'b1;
  assign rise_w = det_w & ~prev_q;
  assign fall_w = ~det_w & prev_q;

  always_comb begin
    unique case (sense_i)
      SENSE_LOW:  hit_w = ~det_w;
      SENSE_RISE: hit_w = rise_w;
      SENSE_FALL: hit_w = fall_w;
      default:    hit_w = rise_w | fall_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= det_w;
      pend_q <= (pend_q & ~clr_i) | hit_w;
    end
  end

  assign pend_o = pend_q;

  assert_quiet_disarmed_R6: assert property (@(posedge clk) disable iff (rst)
    (!arm_i && !$past(arm_i) && !pend_q) |=> !pend_q);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_i) |=> pend_q);

  assert_rise_only_R8: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && sense_i == SENSE_RISE && !det_w) |=> !pend_q);
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic [NPINS-1:0]  level_i,
  input  logic [NPINS-1:0]  pend_i,
  output logic [NPINS-1:0]  arm_o,
  output sense_e            sense_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [NPINS-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o
);
  localparam int SENSE_PAD = NPINS - 2;

  logic [NPINS-1:0] latch_q, dir_q, opt_q;
  sense_e           sense_q;
  logic [NPINS-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      opt_q   <= '0;
      sense_q <= SENSE_LOW;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_LATCH: latch_q <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_OPT:   opt_q   <= bus_wdata;
        A_SENSE: sense_q <= sense_e'(bus_wdata[1:0]);
        default: ;
      endcase
    end
  end

  assign clr_o   = (bus_wr && bus_addr == A_PEND) ? bus_wdata : '0;
  assign arm_o   = opt_q & ~dir_q;
  assign sense_o = sense_q;

  always_comb begin
    unique case (bus_addr)
      A_LATCH: rd_mux = latch_q;
      A_DIR:   rd_mux = dir_q;
      A_OPT:   rd_mux = opt_q;
      A_SENSE: rd_mux = {{SENSE_PAD{1'b0}}, sense_q};
      A_PEND:  rd_mux = pend_i;
      A_LEVEL: rd_mux = level_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      pad_out_o <= '0;
      pad_oe_o  <= '0;
    end else begin
      rvalid_o  <= bus_rd;
      if (bus_rd) rdata_o <= rd_mux;
      pad_out_o <= latch_q & dir_q;
      pad_oe_o  <= dir_q & (opt_q | ~latch_q);
    end
  end

  assert_input_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe_o & ~$past(dir_q)) == '0));

  assert_od_release_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe_o & $past(latch_q & ~opt_q & dir_q)) == '0));
endmodule

// File: rtl/pinbank_edge_irq.sv
module pinbank_edge_irq
  import pinbank_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  logic [NPINS-1:0] level_w, pend_w, arm_w, clr_w;
  sense_e           sense_w;
  logic             irq_q;

  pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(pad_in), .q_o(level_w)
  );

  pinbank_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .level_i(level_w), .pend_i(pend_w),
    .arm_o(arm_w), .sense_o(sense_w), .clr_o(clr_w),
    .rdata_o(bus_rdata), .rvalid_o(bus_rvalid),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pinbank_edge edge_i (
      .clk(clk), .rst(rst),
      .arm_i(arm_w[p]), .level_i(level_w[p]), .sense_i(sense_w),
      .clr_i(clr_w[p]), .pend_o(pend_w[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_w;
  end

  assign irq = irq_q;

  assert_irq_lag_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|pend_w)));
endmodule

// File: tb/pinbank_edge_irq_tb_top.sv
module pinbank_edge_irq_tb_top;
  import pinbank_pkg::*;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [NP-1:0]     bus_wdata = '0;
  logic [NP-1:0]     bus_rdata;
  logic              bus_rvalid;
  logic [NP-1:0]     pad_in = '0;
  logic [NP-1:0]     pad_out, pad_oe;
  logic              irq;

  pinbank_edge_irq #(.NPINS(NP)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  logic [NP-1:0] exp_q[$];
  string         req_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R13 unexpected read data actual=%0h expected=none", bus_rdata);
      end else begin
        check(req_q.pop_front(), {24'd0, bus_rdata}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [NP-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [NP-1:0] exp, string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_pad(logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 pad_oe", {24'd0, pad_oe}, 0);
    check("R1 pad_out", {24'd0, pad_out}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    for (int a = 0; a < 5; a++) rd(a[ADDR_W-1:0], 8'h00, "R1 register reset");

    // R3 latch readback, R13 pad level
    wr(A_LATCH, 8'hA5);
    pad_in = 8'h3C;
    idle(4);
    rd(A_LATCH, 8'hA5, "R3 latch readback");
    rd(A_LEVEL, 8'h3C, "R13 level read");
    check("R2 input no drive", {24'd0, pad_oe}, 0);

    // R4 push-pull
    wr(A_DIR, 8'hFF);
    wr(A_OPT, 8'hFF);
    idle(2);
    check("R4 push-pull oe", {24'd0, pad_oe}, 32'hFF);
    check("R4 push-pull out", {24'd0, pad_out}, 32'hA5);
    // R5 open-drain
    wr(A_OPT, 8'h00);
    idle(2);
    check("R5 open-drain oe", {24'd0, pad_oe}, 32'h5A);
    // R2 mixed direction
    wr(A_OPT, 8'h0F);
    wr(A_DIR, 8'h0F);
    idle(2);
    check("R2 mixed oe", {24'd0, pad_oe}, 32'h0F);
    check("R2 mixed out", {24'd0, pad_out}, 32'h05);
    rd(A_LATCH, 8'hA5, "R3 latch after dir change");

    // R6 disarmed pins ignore pad activity
    wr(A_OPT, 8'h00);
    wr(A_DIR, 8'h00);
    wr(A_SENSE, 8'h03);
    set_pad(8'hFF); idle(3);
    set_pad(8'h00); idle(3);
    set_pad(8'h5A); idle(5);
    rd(A_PEND, 8'h00, "R6 disarmed input");
    wr(A_DIR, 8'hFF);
    wr(A_OPT, 8'hFF);
    set_pad(8'h00); idle(3);
    set_pad(8'hFF); idle(5);
    rd(A_PEND, 8'h00, "R6 output mode");
    check("R6 irq quiet", {31'd0, irq}, 0);
    wr(A_OPT, 8'h00);
    wr(A_DIR, 8'h00);
    set_pad(8'h00); idle(4);

    // R7 arming with low pad
    wr(A_SENSE, 8'h02);
    wr(A_OPT, 8'h01);
    idle(3);
    rd(A_PEND, 8'h01, "R7 arm falling");
    check("R12 irq set", {31'd0, irq}, 1);
    wr(A_PEND, 8'h01);
    idle(2);
    rd(A_PEND, 8'h00, "R11 w1c clear");
    check("R12 irq cleared", {31'd0, irq}, 0);
    wr(A_SENSE, 8'h01);
    wr(A_OPT, 8'h03);
    idle(3);
    rd(A_PEND, 8'h00, "R7 rise-only safe arm");

    // R8 disarming with low pad
    wr(A_OPT, 8'h02);
    idle(3);
    rd(A_PEND, 8'h01, "R8 disarm rising");
    wr(A_PEND, 8'h01);
    wr(A_SENSE, 8'h02);
    wr(A_OPT, 8'h00);
    idle(3);
    rd(A_PEND, 8'h00, "R8 fall-only safe disarm");

    // R9 synchronizer latency
    wr(A_SENSE, 8'h01);
    wr(A_OPT, 8'h04);
    idle(3);
    rd(A_PEND, 8'h00, "R7 rise-only arm pin2");
    set_pad(8'h04);
    idle(3);
    check("R9 irq not before fourth edge", {31'd0, irq}, 0);
    idle(1);
    check("R9 irq at fourth edge", {31'd0, irq}, 1);
    rd(A_PEND, 8'h04, "R9 rising pad pending");
    wr(A_PEND, 8'h04);
    idle(2);

    // R11 clear and new edge in the same cycle
    wr(A_SENSE, 8'h03);
    set_pad(8'h00);
    idle(5);
    rd(A_PEND, 8'h04, "R11 both-edge fall");
    @(negedge clk); pad_in = 8'h04;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 8'h04;
    @(negedge clk); bus_wr = 1'b0;
    idle(2);
    rd(A_PEND, 8'h04, "R11 set wins over clear");
    wr(A_PEND, 8'h00);
    idle(1);
    rd(A_PEND, 8'h04, "R11 zero write no effect");
    wr(A_PEND, 8'h04);
    idle(2);
    rd(A_PEND, 8'h00, "R11 clear without edge");

    // R10 low-level mode
    wr(A_SENSE, 8'h00);
    set_pad(8'h00);
    idle(5);
    rd(A_PEND, 8'h04, "R10 low level sets");
    wr(A_PEND, 8'h04);
    idle(3);
    rd(A_PEND, 8'h04, "R10 level re-sets");
    set_pad(8'h04);
    idle(5);
    wr(A_PEND, 8'h04);
    idle(3);
    rd(A_PEND, 8'h00, "R10 clear sticks when high");
    rd(A_SENSE, 8'h00, "R13 sense readback");
    check("R12 irq idle", {31'd0, irq}, 0);

    idle(3);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R13 missing read data actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule